// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Memory Streamer

This block holds a small byte-wide configuration memory and, from reset onward, sends its whole contents as an endless serial stream on a shared data line. A dedicated transmit clock paces the stream. The transmit clock, the second clock input and the logic all run from one system clock. Both external clocks are oversampled through two-flop synchronisers, so the system clock must run at least about three times faster than the transmit clock.

After reset the line stays released for a short synchronisation preamble. The block then sends one bit per transmit-clock rising edge, most significant bit first. A released ninth slot follows every byte. The byte address walks upward from a configurable start location and wraps at the end of the array.

A second clock input stands for the bidirectional protocol's clock. While it stays high, streaming continues. When a falling edge survives a stability filter, the block enters bidirectional mode, releases the data line for good and stops streaming. Only a reset returns it to streaming mode. The memory contents come from a simple synchronous preload port.

Top module: `cfg_stream_mem`

## Requirements
- R1: While reset is held and on the first cycles after it, `sda_oe` is 0, `sda_out` is 1 and `bidir_mode` is 0.
- R2: For the first `PRE_EDGES` (default 9) transmit-clock rising edges after reset, `sda_oe` stays 0.
- R3: On the next rising edge (the tenth by default), the block drives bit 7 of the byte stored at `START_ADDR`.
- R4: Each further rising edge presents the next data bit, from bit 7 down to bit 0. The output changes on the second system-clock edge after the edge that first samples the transmit clock high.
- R5: After bit 0 of every byte, one rising edge gives a null slot in which `sda_oe` is 0. While `sda_oe` is 0, `sda_out` is 1.
- R6: Consecutive bytes come from consecutive addresses. After address `DEPTH-1` the stream continues with address 0, without a break.
- R7: A low pulse on `bd_clk` that lasts fewer than `FILT_CYC` synchronised samples is ignored: `bidir_mode` stays 0 and streaming goes on.
- R8: A low level on `bd_clk` that holds for `FILT_CYC` synchronised samples sets `bidir_mode` to 1 and forces `sda_oe` to 0.
- R9: Once `bidir_mode` is 1, it stays 1, and transmit-clock edges no longer drive the line, whatever `bd_clk` does afterward.
- R10: A reset leaves bidirectional mode and restarts the preamble and the stream from `START_ADDR`.
- R11: When `pl_we` is 1, `pl_data` is written to location `pl_addr`, and the stream sends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (stands in for power-up) |
| tx_clk | input | 1 | Transmit clock for streaming mode |
| bd_clk | input | 1 | Bidirectional-mode clock, idle high |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | $clog2(DEPTH) | Preload address |
| pl_data | input | WIDTH | Preload data |
| sda_oe | output | 1 | Data-line drive enable (1 drives, 0 releases) |
| sda_out | output | 1 | Data-line value when driven |
| bidir_mode | output | 1 | 1 once bidirectional mode is entered |

## Verification
The following properties are checked on every cycle:
- the line stays released during the preamble and in bidirectional mode;
- the mode flag is sticky;
- `sda_out` idles high whenever the line is released;
- a newly driven bit always follows a detected transmit edge.

Some properties hold only across many cycles, so only the bench scenarios can show them:
- bit order;
- the exact byte at each address and the wrap from the last location to 0;
- glitch rejection against a valid fall;
- a restart after reset.

A cycle-accurate model in the bench checks each of these.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_BIDIR  = 1'b1
  } mode_e;
endpackage

// File: rtl/cfg_sync2.sv
// Two-flop synchroniser with a selectable reset level.
module cfg_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  logic [1:0] ff;
  always_ff @(posedge clk) begin
    if (rst) ff <= {2{RST_VAL}};
    else     ff <= {ff[0], din};
  end
  assign level = ff[1];
endmodule

// File: rtl/cfg_glitch_filter.sv
// The output follows the input only after the input has differed for FILT_CYC consecutive samples.
module cfg_glitch_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int CW = $clog2(FILT_CYC + 1);
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (lvl_in == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      filt_q <= lvl_in;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
  assign lvl_out = filt_q;
endmodule

// File: rtl/cfg_stream_engine.sv
// Preamble counter, bit slot sequencer, address walker and the array, which is written so that block RAM can be inferred.
module cfg_stream_engine #(
  parameter int DEPTH      = 128,
  parameter int WIDTH      = 8,
  parameter int PRE_EDGES  = 9,
  parameter int START_ADDR = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_lvl,
  input  logic                     halt,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  output logic                     sda_oe,
  output logic                     sda_out,
  output logic                     step,
  output logic                     pre_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(WIDTH + 1);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int PW = $clog2(PRE_EDGES + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;
  logic [AW-1:0]    addr_q;
  logic [SW-1:0]    slot_q;
  logic [PW-1:0]    pre_q;
  logic             tx_prev;
  logic             oe_q, out_q;
  logic [IW-1:0]    bit_idx;

  // Array write port and a registered read of the current byte.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[addr_q];
  end

  assign step     = tx_lvl & ~tx_prev;
  assign pre_done = (pre_q == PW'(PRE_EDGES));
  assign bit_idx  = IW'(WIDTH - 1) - slot_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_prev <= 1'b0;
      pre_q   <= '0;
      slot_q  <= '0;
      addr_q  <= AW'(START_ADDR);
      oe_q    <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      tx_prev <= tx_lvl;
      if (halt) begin
        oe_q  <= 1'b0;
        out_q <= 1'b1;
      end else if (step) begin
        if (!pre_done) begin
          pre_q <= pre_q + 1'b1;
        end else if (slot_q != SW'(WIDTH)) begin
          oe_q   <= 1'b1;
          out_q  <= rd_q[bit_idx];
          slot_q <= slot_q + 1'b1;
        end else begin
          oe_q   <= 1'b0;
          out_q  <= 1'b1;
          slot_q <= '0;
          addr_q <= (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
        end
      end
    end
  end

  assign sda_oe  = oe_q;
  assign sda_out = out_q;
endmodule

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem #(
  parameter int DEPTH      = 128,
  parameter int WIDTH      = 8,
  parameter int PRE_EDGES  = 9,
  parameter int FILT_CYC   = 4,
  parameter int START_ADDR = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_clk,
  input  logic                     bd_clk,
  input  logic                     pl_we,
  input  logic [$clog2(DEPTH)-1:0] pl_addr,
  input  logic [WIDTH-1:0]         pl_data,
  output logic                     sda_oe,
  output logic                     sda_out,
  output logic                     bidir_mode
);
  import cfg_stream_pkg::*;

  logic  tx_lvl, bd_lvl, bd_filt;
  logic  halt;
  logic  eng_step, eng_pre_done;
  mode_e mode_q;

  cfg_sync2 #(.RST_VAL(1'b0)) u_tx_sync (
    .clk(clk), .rst(rst), .din(tx_clk), .level(tx_lvl)
  );

  cfg_sync2 #(.RST_VAL(1'b1)) u_bd_sync (
    .clk(clk), .rst(rst), .din(bd_clk), .level(bd_lvl)
  );

  cfg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_bd_filt (
    .clk(clk), .rst(rst), .lvl_in(bd_lvl), .lvl_out(bd_filt)
  );

  // Sticky mode latch: a qualified low level on the filtered clock enters bidirectional mode.
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MODE_STREAM;
    else if (!bd_filt) mode_q <= MODE_BIDIR;
  end

  assign halt       = (mode_q == MODE_BIDIR) | ~bd_filt;
  assign bidir_mode = (mode_q == MODE_BIDIR);

  cfg_stream_engine #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .PRE_EDGES(PRE_EDGES), .START_ADDR(START_ADDR)
  ) u_engine (
    .clk(clk), .rst(rst), .tx_lvl(tx_lvl), .halt(halt),
    .wr_en(pl_we), .wr_addr(pl_addr), .wr_data(pl_data),
    .sda_oe(sda_oe), .sda_out(sda_out),
    .step(eng_step), .pre_done(eng_pre_done)
  );
endmodule

// File: rtl/cfg_stream_mem_chk.sv
module cfg_stream_mem_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic sda_out,
  input logic bidir_mode,
  input logic step,
  input logic pre_done
);
  // R2: the line stays released until the preamble has completed
  p_preamble_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !pre_done |-> !sda_oe);

  // R4: a bit is first driven only after a detected transmit edge
  p_drive_after_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(step));

  // R5: a released line idles high
  p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
    !sda_oe |-> sda_out);

  // R8: bidirectional mode never drives the line
  p_bidir_release_r8: assert property (@(posedge clk) disable iff (rst)
    bidir_mode |-> !sda_oe);

  // R9: the mode flag is sticky until reset
  p_mode_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    bidir_mode |=> bidir_mode);
endmodule

bind cfg_stream_mem cfg_stream_mem_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .sda_out(sda_out),
  .bidir_mode(bidir_mode), .step(eng_step), .pre_done(eng_pre_done)
);

// File: tb/cfg_stream_mem_bench.sv
`timescale 1ns/100ps
module cfg_stream_mem_bench;
  localparam int DEPTH = 128;
  localparam int W     = 8;
  localparam int PRE   = 9;
  localparam int FILT  = 4;
  localparam int START = 124;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_clk = 1'b0;
  logic bd_clk = 1'b1;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [W-1:0]  pl_data = '0;
  logic sda_oe, sda_out, bidir_mode;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit started = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  cfg_stream_mem #(
    .DEPTH(DEPTH), .WIDTH(W), .PRE_EDGES(PRE), .FILT_CYC(FILT), .START_ADDR(START)
  ) u_cfg_stream_mem (
    .clk(clk), .rst(rst), .tx_clk(tx_clk), .bd_clk(bd_clk),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .sda_oe(sda_oe), .sda_out(sda_out), .bidir_mode(bidir_mode)
  );

  // Behavioural reference model
  logic [W-1:0] mm [DEPTH];
  int txh[4], bdh[4];
  int m_pre, m_slot, m_addr, zrun;
  bit m_oe, m_out, m_mode, m_pend;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin txh[i] = 0; bdh[i] = 1; end
      m_pre = 0; m_slot = 0; m_addr = START; zrun = 0;
      m_oe = 0; m_out = 1; m_mode = 0; m_pend = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin txh[i] = txh[i-1]; bdh[i] = bdh[i-1]; end
      txh[0] = tx_clk; bdh[0] = bd_clk;
      if (m_pend) m_mode = 1;
      zrun = (bdh[2] == 0) ? zrun + 1 : 0;
      if (zrun >= FILT) m_pend = 1;
      if (m_mode) begin
        m_oe = 0; m_out = 1;
      end else if (txh[2] == 1 && txh[3] == 0) begin
        if (m_pre < PRE) m_pre++;
        else if (m_slot < W) begin
          m_oe = 1; m_out = mm[m_addr][W-1-m_slot]; m_slot++;
        end else begin
          m_oe = 0; m_out = 1; m_slot = 0; m_addr = (m_addr + 1) % DEPTH;
        end
      end
    end
  end

  // Per-cycle comparison, made away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (sda_oe !== m_oe || sda_out !== m_out || bidir_mode !== m_mode) begin
        fails++;
        $display("FAIL %s cycle model: actual oe=%b out=%b mode=%b expected oe=%b out=%b mode=%b",
                 tag, sda_oe, sda_out, bidir_mode, m_oe, m_out, m_mode);
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tx_pulse(int lo, int hi);
    tx_clk = 1'b0;
    repeat (lo) @(negedge clk);
    tx_clk = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx_clk = 1'b0; bd_clk = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  // Receives one byte and its null slot; returns the assembled byte
  task automatic rx_byte(int lo, int hi, string req, output logic [W-1:0] got);
    for (int b = W - 1; b >= 0; b--) begin
      tx_pulse(lo, hi);
      check(req, sda_oe, 1'b1);
      got[b] = sda_out;
    end
    tx_pulse(lo, hi);
    check("R5 null slot", sda_oe, 1'b0);
  endtask

  initial begin
    logic [W-1:0] got;
    // R11: preload during reset
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      pl_we = 1'b1; pl_addr = AW'(i);
      pl_data = W'((i * 29 + 7) ^ (i >> 2));
      mm[i] = pl_data;
      @(negedge clk);
    end
    pl_we = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 oe", sda_oe, 1'b0);
    check("R1 out", sda_out, 1'b1);
    check("R1 mode", bidir_mode, 1'b0);

    tag = "R2";
    for (int e = 0; e < PRE; e++) begin
      tx_pulse(3, 3);
      check("R2 preamble", sda_oe, 1'b0);
    end

    // R3 / R4 / R6: bytes 124..127 then 0..3 across the wrap, with two pulse shapes
    tag = "R4";
    for (int n = 0; n < 8; n++) begin
      if (n & 1) rx_byte(2, 5, "R4 bit drive", got);
      else       rx_byte(3, 3, "R4 bit drive", got);
      if (n == 0) check("R3 first byte", got == mm[START], 1'b1);
      else        check("R6 byte sequence", got == mm[(START + n) % DEPTH], 1'b1);
    end

    // R7: short glitch on bd_clk
    tag = "R7";
    bd_clk = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    bd_clk = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 glitch ignored", bidir_mode, 1'b0);
    rx_byte(3, 3, "R7 stream continues", got);
    check("R7 byte after glitch", got == mm[(START + 8) % DEPTH], 1'b1);

    // R8: valid fall mid-byte
    tag = "R8";
    tx_pulse(3, 3);
    tx_pulse(3, 3);
    bd_clk = 1'b0;
    repeat (FILT + 6) @(negedge clk);
    check("R8 mode set", bidir_mode, 1'b1);
    check("R8 line released", sda_oe, 1'b0);

    // R9: sticky, no further drive
    tag = "R9";
    bd_clk = 1'b1;
    for (int e = 0; e < 30; e++) begin
      tx_pulse(3, 3);
      check("R9 no drive", sda_oe, 1'b0);
    end
    check("R9 mode sticky", bidir_mode, 1'b1);

    // R10 / R11: reset with a new value at the start address
    tag = "R10";
    @(negedge clk);
    rst = 1'b1; tx_clk = 1'b0; bd_clk = 1'b1;
    pl_we = 1'b1; pl_addr = AW'(START); pl_data = 8'hA5; mm[START] = 8'hA5;
    @(negedge clk);
    pl_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 mode cleared", bidir_mode, 1'b0);
    for (int e = 0; e < PRE; e++) begin
      tx_pulse(3, 3);
      check("R10 preamble again", sda_oe, 1'b0);
    end
    rx_byte(3, 4, "R10 stream resumes", got);
    check("R11 preloaded byte", got == 8'hA5, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule